// File: doc/BRIEF.md
# Low-Side Channel Supervisor

This block is the digital supervisor for one low-side power switch channel. It takes a common enable, the channel's command input and four comparator flags that the analog front end has already resolved: overcurrent, on-state undercurrent, output below the off-state voltage threshold, and overtemperature. From these it produces the gate-on command for the power stage and an active-low diagnostic flag for the host controller.

The gate follows the command input when enable is high and no protection is active. A sustained overcurrent is tolerated for a programmable delay while the analog stage limits the current. After that delay the channel is latched off. Overtemperature turns the gate off at once and latches a low diagnostic. Both latches are released only when the command input goes low. The open-load report in the on state and the low-voltage report in the off state each pass a programmable filter delay before they pull the diagnostic low. All delays count periods of a `tick` strobe, which is normally one microsecond. Every asynchronous input passes through a synchroniser first.

Top module: `lsd_channel_supervisor`

## Requirements
- R1: While enable is low, `gate_on` is 0 and `diag_n` is 0 whatever the command input is.
- R2: With enable high and no fault, `gate_on` equals the command input and `diag_n` is 1 in both the on and off states.
- R3: In the on state, an undercurrent flag held for OPEN_TICKS tick periods drives `diag_n` to 0 while `gate_on` stays 1. A shorter undercurrent leaves `diag_n` at 1.
- R4: An overcurrent flag held in the on state for OL_TICKS tick periods latches the channel off (`gate_on` 0, `diag_n` 0). The latch stays set after the flag drops. An overcurrent that ends before expiry restarts the timer from zero and has no effect on the outputs.
- R5: The overtemperature flag forces `gate_on` to 0 and `diag_n` to 0 within the fixed pipeline latency, whatever enable and input are.
- R6: After the overtemperature flag clears with the input still high, `gate_on` returns to 1, but `diag_n` stays 0 until the input goes low.
- R7: If the input stays high through an overtemperature lasting OL_TICKS tick periods, the overload latch sets, so `gate_on` stays 0 after the temperature flag clears.
- R8: In the off state with enable high, a low-output-voltage flag held for HL_TICKS tick periods drives `diag_n` to 0. A shorter one has no effect.
- R9: A low command input clears both the overload latch and the overtemperature latch. A later high input switches the channel on again with `diag_n` at 1.
- R10: Each asynchronous input passes SYNC_STAGES flops. The outputs are registered once more, so with the default of 2 stages a change at an input port reaches the outputs on the third rising edge.
- R11: During and right after reset, `gate_on` is 0 and `diag_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Single-cycle timebase strobe, synchronous to clk |
| en_a | input | 1 | Common enable, asynchronous |
| in_a | input | 1 | Channel command input, asynchronous |
| oc_a | input | 1 | Overcurrent comparator flag |
| uc_a | input | 1 | On-state undercurrent (open load) flag |
| lowv_a | input | 1 | Output below off-state threshold flag |
| ot_a | input | 1 | Overtemperature flag |
| gate_on | output | 1 | Gate drive command, 1 = switch on |
| diag_n | output | 1 | Diagnostic flag, 0 = fault or disabled |

## Verification
The assertions assume that `tick` is a synchronous single-cycle strobe and that the flags are stable levels. Glitches shorter than a clock period are not assumed to be filtered beyond what the synchroniser gives. The latch and timer properties also assume that an overload can only be armed while the command input is high. The stimulus keeps within these limits. It changes inputs only on falling clock edges and holds each level for many clock cycles. It raises `tick` for exactly one cycle in every four. It holds or releases each fault flag for tick counts on either side of the configured limits.

// File: rtl/lsd_pkg.sv
package lsd_pkg;

   // Index of each asynchronous input inside the synchroniser vector
   localparam int unsigned IDX_EN   = 0;
   localparam int unsigned IDX_IN   = 1;
   localparam int unsigned IDX_OC   = 2;
   localparam int unsigned IDX_UC   = 3;
   localparam int unsigned IDX_LOWV = 4;
   localparam int unsigned IDX_OT   = 5;
   localparam int unsigned NUM_FLAGS = 6;

   // Reason that the diagnostic flag is pulled low, in priority order
   typedef enum logic [2:0] {
      CAUSE_NONE     = 3'd0,
      CAUSE_OVERTEMP = 3'd1,
      CAUSE_DISABLED = 3'd2,
      CAUSE_OVERLOAD = 3'd3,
      CAUSE_OPEN_ON  = 3'd4,
      CAUSE_LOW_OFF  = 3'd5
   } diag_cause_e;

   typedef struct packed {
      logic en;
      logic cmd;
      logic oc;
      logic uc;
      logic lowv;
      logic ot;
   } chan_flags_t;

endpackage

// File: rtl/lsd_sync.sv
module lsd_sync #(
   parameter int unsigned WIDTH  = 6,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("lsd_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("lsd_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] stage_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= d_async;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/lsd_tick_timer.sv
module lsd_tick_timer #(
   parameter int unsigned LIMIT = 160
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic run,
   output logic expired
);

   localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LIM_C = CW'(LIMIT);

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("lsd_tick_timer: LIMIT must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic          at_limit;

   assign at_limit = (cnt_q == LIM_C);
   assign expired  = run && at_limit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run) begin
         cnt_q <= '0;
      end else if (tick && !at_limit) begin
         cnt_q <= cnt_q + CW'(1);
      end
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LIM_C);  // R4
   AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt_q == '0));  // R4
   AST_CNT_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !tick) |=> $stable(cnt_q) || !$past(run));  // R3

endmodule

// File: rtl/lsd_fault_latch.sv
module lsd_fault_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q
);

   // Set dominates clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= 1'b0;
      else if (set_i) q <= 1'b1;
      else if (clr_i) q <= 1'b0;
   end

   AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (q && !clr_i) |=> q);  // R4
   AST_LATCH_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !q);  // R9

endmodule

// File: rtl/lsd_diag_resolve.sv
module lsd_diag_resolve
   import lsd_pkg::*;
(
   input  chan_flags_t flags,
   input  logic        ot_latched,
   input  logic        ol_latched,
   input  logic        open_qual,
   input  logic        low_qual,
   output diag_cause_e cause,
   output logic        diag_ok
);

   always_comb begin
      if (flags.ot || ot_latched)  cause = CAUSE_OVERTEMP;
      else if (!flags.en)          cause = CAUSE_DISABLED;
      else if (ol_latched)         cause = CAUSE_OVERLOAD;
      else if (flags.cmd)          cause = open_qual ? CAUSE_OPEN_ON : CAUSE_NONE;
      else                         cause = low_qual  ? CAUSE_LOW_OFF : CAUSE_NONE;
   end

   assign diag_ok = (cause == CAUSE_NONE);

endmodule

// File: rtl/lsd_channel_supervisor.sv
module lsd_channel_supervisor
   import lsd_pkg::*;
#(
   parameter int unsigned OL_TICKS    = 160,
   parameter int unsigned OPEN_TICKS  = 30,
   parameter int unsigned HL_TICKS    = 65,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic en_a,
   input  logic in_a,
   input  logic oc_a,
   input  logic uc_a,
   input  logic lowv_a,
   input  logic ot_a,
   output logic gate_on,
   output logic diag_n
);

   generate
      if (OL_TICKS < 1 || OPEN_TICKS < 1 || HL_TICKS < 1) begin : g_bad_delays
         $error("lsd_channel_supervisor: delay counts must be at least 1");
      end
   endgenerate

   logic [NUM_FLAGS-1:0] raw_vec;
   logic [NUM_FLAGS-1:0] sync_vec;
   chan_flags_t          f;

   assign raw_vec[IDX_EN]   = en_a;
   assign raw_vec[IDX_IN]   = in_a;
   assign raw_vec[IDX_OC]   = oc_a;
   assign raw_vec[IDX_UC]   = uc_a;
   assign raw_vec[IDX_LOWV] = lowv_a;
   assign raw_vec[IDX_OT]   = ot_a;

   lsd_sync #(
      .WIDTH  (NUM_FLAGS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (raw_vec),
      .q_sync  (sync_vec)
   );

   assign f.en   = sync_vec[IDX_EN];
   assign f.cmd  = sync_vec[IDX_IN];
   assign f.oc   = sync_vec[IDX_OC];
   assign f.uc   = sync_vec[IDX_UC];
   assign f.lowv = sync_vec[IDX_LOWV];
   assign f.ot   = sync_vec[IDX_OT];

   // Fault latches
   logic ol_lat, ot_lat;
   logic ol_run, ol_expired;
   logic open_run, open_qual;
   logic low_run, low_qual;

   // The overload delay runs on overcurrent, and also on overtemperature
   // with the input still high (the output sees an overdrop in both cases)
   assign ol_run   = f.en && f.cmd && (f.oc || f.ot) && !ol_lat;
   assign open_run = f.en && f.cmd && f.uc;
   assign low_run  = f.en && !f.cmd && f.lowv;

   lsd_tick_timer #(.LIMIT(OL_TICKS)) u_ol_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .run     (ol_run),
      .expired (ol_expired)
   );

   lsd_tick_timer #(.LIMIT(OPEN_TICKS)) u_open_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .run     (open_run),
      .expired (open_qual)
   );

   lsd_tick_timer #(.LIMIT(HL_TICKS)) u_low_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .run     (low_run),
      .expired (low_qual)
   );

   lsd_fault_latch u_ol_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (ol_expired),
      .clr_i (!f.cmd),
      .q     (ol_lat)
   );

   lsd_fault_latch u_ot_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (f.ot),
      .clr_i (!f.cmd),
      .q     (ot_lat)
   );

   diag_cause_e cause;
   logic        diag_ok;

   lsd_diag_resolve u_resolve (
      .flags      (f),
      .ot_latched (ot_lat),
      .ol_latched (ol_lat),
      .open_qual  (open_qual),
      .low_qual   (low_qual),
      .cause      (cause),
      .diag_ok    (diag_ok)
   );

   logic gate_q, diag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_q <= 1'b0;
         diag_q <= 1'b0;
      end else begin
         gate_q <= f.en && f.cmd && !f.ot && !ol_lat;
         diag_q <= diag_ok;
      end
   end

   assign gate_on = gate_q;
   assign diag_n  = diag_q;

   AST_EN_LOW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !f.en |=> (!gate_on && !diag_n));  // R1
   AST_OT_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      f.ot |=> (!gate_on && !diag_n));  // R5
   AST_OL_BLOCKS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      ol_lat |=> !gate_on);  // R4
   AST_OL_CLEARS_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !f.cmd |=> !ol_lat);  // R9
   AST_OT_CLEARS_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!f.cmd && !f.ot) |=> !ot_lat);  // R9
   AST_OT_DIAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (ot_lat && f.cmd) |=> !diag_n);  // R6
   AST_OPEN_KEEPS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (open_qual && !f.ot && !ol_lat) |=> gate_on);  // R3

endmodule

// File: tb/sim_lsd_channel_supervisor.sv
module sim_lsd_channel_supervisor;

   localparam int OL_T   = 20;
   localparam int OPEN_T = 6;
   localparam int HL_T   = 10;
   localparam int TDIV   = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0;
   logic en_a = 0, in_a = 0, oc_a = 0, uc_a = 0, lowv_a = 0, ot_a = 0;
   logic gate_on, diag_n;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;
   string cur_req = "R11";

   always #4 clk = ~clk;  // 125 MHz

   lsd_channel_supervisor #(
      .OL_TICKS    (OL_T),
      .OPEN_TICKS  (OPEN_T),
      .HL_TICKS    (HL_T),
      .SYNC_STAGES (2)
   ) u0 (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .en_a    (en_a),
      .in_a    (in_a),
      .oc_a    (oc_a),
      .uc_a    (uc_a),
      .lowv_a  (lowv_a),
      .ot_a    (ot_a),
      .gate_on (gate_on),
      .diag_n  (diag_n)
   );

   // Timebase: one-cycle strobe every TDIV clocks
   int tdiv_cnt = 0;
   always @(negedge clk) begin
      tdiv_cnt = (tdiv_cnt + 1) % TDIV;
      tick = (tdiv_cnt == 0);
   end

   // Behavioural reference model
   bit p1[6], p2[6];          // delay-line history of en,in,oc,uc,lowv,ot
   int m_ol, m_open, m_low;   // elapsed tick counts
   bit m_ol_lat, m_ot_lat, m_gate, m_diag;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         foreach (p1[i]) begin p1[i] = 0; p2[i] = 0; end
         m_ol = 0; m_open = 0; m_low = 0;
         m_ol_lat = 0; m_ot_lat = 0; m_gate = 0; m_diag = 0;
      end else begin
         bit en, cmd, oc, uc, lv, ot, ol_go, op_go, lo_go, ol_done, op_done, lo_done;
         en = p2[0]; cmd = p2[1]; oc = p2[2]; uc = p2[3]; lv = p2[4]; ot = p2[5];
         ol_go = en && cmd && (oc || ot) && !m_ol_lat;
         op_go = en && cmd && uc;
         lo_go = en && !cmd && lv;
         ol_done = ol_go && (m_ol == OL_T);
         op_done = op_go && (m_open == OPEN_T);
         lo_done = lo_go && (m_low == HL_T);
         m_gate = en && cmd && !ot && !m_ol_lat;
         if (ot || m_ot_lat)  m_diag = 0;
         else if (!en)        m_diag = 0;
         else if (m_ol_lat)   m_diag = 0;
         else if (cmd)        m_diag = !op_done;
         else                 m_diag = !lo_done;
         if (ol_done) m_ol_lat = 1; else if (!cmd) m_ol_lat = 0;
         if (ot) m_ot_lat = 1; else if (!cmd) m_ot_lat = 0;
         m_ol   = !ol_go ? 0 : (tick && m_ol < OL_T)     ? m_ol + 1   : m_ol;
         m_open = !op_go ? 0 : (tick && m_open < OPEN_T) ? m_open + 1 : m_open;
         m_low  = !lo_go ? 0 : (tick && m_low < HL_T)    ? m_low + 1  : m_low;
         p2 = p1;
         p1[0] = en_a; p1[1] = in_a; p1[2] = oc_a; p1[3] = uc_a; p1[4] = lowv_a; p1[5] = ot_a;
      end
   end

   // Compare with the model on every clock, away from the active edge
   always @(negedge clk) begin
      n_checks++;
      if (gate_on !== m_gate || diag_n !== m_diag) begin
         n_fail++;
         $display("FAIL %s model compare: gate_on=%b diag_n=%b expected gate_on=%b diag_n=%b",
                  cur_req, gate_on, diag_n, m_gate, m_diag);
      end
   end

   task automatic check_out(input string req, input logic exp_gate, input logic exp_diag);
      n_checks++;
      if (gate_on !== exp_gate || diag_n !== exp_diag) begin
         n_fail++;
         $display("FAIL %s: gate_on=%b diag_n=%b expected gate_on=%b diag_n=%b",
                  req, gate_on, diag_n, exp_gate, exp_diag);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   // Watchdog
   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: run did not complete, cycles=%0d expected<=150000", cycles);
         finish_run();
      end
   end

   initial begin
      wait_cyc(3);
      cur_req = "R11";
      check_out("R11 in reset", 1'b0, 1'b0);
      rst_n = 1'b1;
      wait_cyc(2);
      check_out("R11 after reset", 1'b0, 1'b0);

      // R1: disabled, input high
      cur_req = "R1";
      in_a = 1; wait_cyc(6);
      check_out("R1 enable low input high", 1'b0, 1'b0);

      // R10: latency from port to outputs
      cur_req = "R10";
      in_a = 0; wait_cyc(6);
      en_a = 1; in_a = 1;
      wait_cyc(2);
      check_out("R10 after two edges", 1'b0, 1'b0);
      wait_cyc(1);
      check_out("R10 after three edges", 1'b1, 1'b1);

      // R2: normal on and off
      cur_req = "R2";
      wait_cyc(4);
      check_out("R2 on", 1'b1, 1'b1);
      in_a = 0; wait_cyc(6);
      check_out("R2 off", 1'b0, 1'b1);

      // R3: open load in on state, short then long
      cur_req = "R3";
      in_a = 1; uc_a = 1; wait_cyc((OPEN_T - 2) * TDIV);
      check_out("R3 before filter", 1'b1, 1'b1);
      wait_cyc(4 * TDIV + 6);
      check_out("R3 after filter", 1'b1, 1'b0);
      uc_a = 0; wait_cyc(6);
      check_out("R3 cleared", 1'b1, 1'b1);

      // R4: short overcurrent restarts timer; long one latches
      cur_req = "R4";
      oc_a = 1; wait_cyc((OL_T - 4) * TDIV);
      oc_a = 0; wait_cyc(6);
      oc_a = 1; wait_cyc((OL_T - 4) * TDIV);
      check_out("R4 no trip before delay", 1'b1, 1'b1);
      oc_a = 0; wait_cyc(6);
      oc_a = 1; wait_cyc((OL_T + 3) * TDIV + 6);
      check_out("R4 tripped", 1'b0, 1'b0);
      oc_a = 0; wait_cyc(10);
      check_out("R4 latch holds", 1'b0, 1'b0);

      // R9: low input releases the overload latch
      cur_req = "R9";
      in_a = 0; wait_cyc(6);
      in_a = 1; wait_cyc(6);
      check_out("R9 overload released", 1'b1, 1'b1);

      // R5 / R6: short overtemperature
      cur_req = "R5";
      ot_a = 1; wait_cyc(3);
      check_out("R5 overtemp forces off", 1'b0, 1'b0);
      cur_req = "R6";
      wait_cyc(3 * TDIV);
      ot_a = 0; wait_cyc(6);
      check_out("R6 gate back, diag held", 1'b1, 1'b0);
      in_a = 0; wait_cyc(6);
      check_out("R6 off after release", 1'b0, 1'b1);
      in_a = 1; wait_cyc(6);
      check_out("R9 overtemp released", 1'b1, 1'b1);

      // R5 with enable low
      cur_req = "R5";
      en_a = 0; ot_a = 1; wait_cyc(6);
      check_out("R5 overtemp while disabled", 1'b0, 1'b0);
      ot_a = 0; en_a = 1; in_a = 0; wait_cyc(6);
      in_a = 1; wait_cyc(6);

      // R7: long overtemperature with input high sets overload latch
      cur_req = "R7";
      ot_a = 1; wait_cyc((OL_T + 3) * TDIV + 6);
      ot_a = 0; wait_cyc(8);
      check_out("R7 overload latched by overtemp", 1'b0, 1'b0);
      in_a = 0; wait_cyc(6);
      in_a = 1; wait_cyc(6);
      check_out("R9 both latches released", 1'b1, 1'b1);

      // R8: low output voltage in off state, short then long
      cur_req = "R8";
      in_a = 0; wait_cyc(6);
      lowv_a = 1; wait_cyc((HL_T - 3) * TDIV);
      check_out("R8 before delay", 1'b0, 1'b1);
      lowv_a = 0; wait_cyc(6);
      lowv_a = 1; wait_cyc((HL_T + 3) * TDIV + 6);
      check_out("R8 after delay", 1'b0, 1'b0);
      lowv_a = 0; wait_cyc(6);
      check_out("R8 cleared", 1'b0, 1'b1);

      finish_run();
   end

endmodule